// File: doc/BRIEF.md
# Accumulate, Round, Window and Clamp Output Stage

This block is the back end of a sum-of-products filter. Each clock it takes a 32-bit two's complement sum of products. Per cycle, it either adds that sum to a running total or starts a new total from it. It adds a rounding or offset constant taken from a bank of sixteen 32-bit registers. It then cuts a 16-bit window out of the 32-bit result at a bit offset given by a shift control. If limiting is on, it clamps the window into a signed range taken from a bank of sixteen upper/lower pairs. The result goes into an output register that loads only while its active-low enable is low.

Every control is sampled in the same cycle as the sum it applies to. The controls travel down the pipeline with that sum: the round select, shift, limit select, limit enable and output enable. A caller can therefore change the configuration on any cycle without having to line up skewed controls. The two register banks are written through simple parallel write ports, one entry per cycle per bank.

Top module: `sop_post_stage`

## Requirements
- R1: When `acc_en` is low in a cycle, the accumulator discards its previous total and takes that cycle's `sum_in` unchanged.
- R2: When `acc_en` is high in a cycle, the accumulator becomes its previous total plus that cycle's `sum_in`.
- R3: The rounding register addressed by `rnd_sel` is added, modulo 2^32, to the accumulator value before windowing.
- R4: For a shift value s from 0 to 16, the window is bits [s+15:s] of the rounded value. Shift values 17 to 31 behave exactly like 16.
- R5: With `lim_en_n` low, a window that is signed-greater than the selected upper bound is replaced by the upper bound.
- R6: With `lim_en_n` low, a window that is not above the upper bound but is signed-less than the selected lower bound is replaced by the lower bound. The upper test takes priority when the bounds cross.
- R7: With `lim_en_n` high, the window passes to the output unclamped whatever the limit registers hold.
- R8: Accumulation and rounding wrap modulo 2^32 with no saturation.
- R9: When `out_en_n` is low, the output register loads the result. When it is high, `dout` keeps its previous value.
- R10: The result for a `sum_in` appears on `dout` two rising edges after the edge that samples it. All controls are taken from the same cycle as that sum.
- R11: A bank write with `rnd_wr_en` or `lim_wr_en` high stores the data into the indexed entry. The new value is used by any result computed after that edge.
- R12: Synchronous reset clears the accumulator, both register banks and `dout` to zero. The first cycle's result after reset is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sum_in | input | 32 | Signed sum of products for this cycle |
| acc_en | input | 1 | High: add to running total; low: restart total |
| rnd_sel | input | 4 | Rounding register select |
| shift_amt | input | 5 | Window offset (values above 16 act as 16) |
| lim_sel | input | 4 | Limit pair select |
| lim_en_n | input | 1 | Active-low limit enable |
| out_en_n | input | 1 | Active-low output register load enable |
| rnd_wr_en | input | 1 | Rounding bank write strobe |
| rnd_wr_idx | input | 4 | Rounding bank write index |
| rnd_wr_data | input | 32 | Rounding bank write data |
| lim_wr_en | input | 1 | Limit bank write strobe |
| lim_wr_idx | input | 4 | Limit bank write index |
| lim_wr_upper | input | 16 | Signed upper bound to write |
| lim_wr_lower | input | 16 | Signed lower bound to write |
| dout | output | 16 | Registered filter output |

## Verification
The assertions check several things on every cycle: restart and accumulate arithmetic on the accumulator, the hold of `dout` under a high output enable, clearing on reset, and that an enabled clamp never leaves a well-formed range. What they cannot show is correct window extraction for every shift value, the choice of the right rounding and limit entries, wrap at the 32-bit boundary, the priority of the upper bound when the bounds cross, and two-cycle alignment of controls with data. Only the bench's sweeps against its arithmetic model show those.

// File: rtl/sop_post_pkg.sv
`timescale 1ns/1ps
package sop_post_pkg;

    localparam int SUM_W   = 32;
    localparam int OUT_W   = 16;
    localparam int NREG    = 16;
    localparam int SEL_W   = $clog2(NREG);
    localparam int SHIFT_W = 5;
    localparam int MAX_SH  = SUM_W - OUT_W;

    // controls captured together with a sum and carried to stage two
    typedef struct packed {
        logic [SEL_W-1:0]   rnd_sel;
        logic [SHIFT_W-1:0] shift;
        logic [SEL_W-1:0]   lim_sel;
        logic               lim_en_n;
        logic               out_en_n;
    } stage_ctrl_t;

    localparam stage_ctrl_t CTRL_RST = '{
        rnd_sel:  '0,
        shift:    '0,
        lim_sel:  '0,
        lim_en_n: 1'b1,
        out_en_n: 1'b1
    };

    // shift values beyond the top window saturate to it
    function automatic logic [SHIFT_W-1:0] sat_shift(input logic [SHIFT_W-1:0] s);
        if (int'(s) > MAX_SH)
            return SHIFT_W'(MAX_SH);
        return s;
    endfunction

endpackage

// File: rtl/sop_post_regfile.sv
`timescale 1ns/1ps
module sop_post_regfile #(
    parameter int W = 32,
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] widx,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ridx,
    output logic [W-1:0]         rdata
);
    logic [W-1:0] mem_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (we && (int'(widx) == g))
                mem_q[g] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/sop_post_accum.sv
`timescale 1ns/1ps
module sop_post_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_en,
    input  logic [W-1:0] sum_in,
    output logic [W-1:0] acc_q
);
    logic [W-1:0] acc_d;

    // wraps modulo 2^W by width
    assign acc_d = acc_en ? (acc_q + sum_in) : sum_in;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/sop_post_window.sv
`timescale 1ns/1ps
module sop_post_window
    import sop_post_pkg::*;
#(
    parameter int IN_W  = SUM_W,
    parameter int WIN_W = OUT_W,
    parameter int SH_W  = SHIFT_W
) (
    input  logic [IN_W-1:0]  acc,
    input  logic [IN_W-1:0]  rnd,
    input  logic [SH_W-1:0]  shift,
    output logic [WIN_W-1:0] win
);
    localparam int TOP_SH = IN_W - WIN_W;

    logic [IN_W-1:0]  rounded;
    logic [SH_W-1:0]  sh_eff;
    logic [WIN_W-1:0] cand [TOP_SH+1];

    assign rounded = acc + rnd;

    always_comb begin
        if (int'(shift) > TOP_SH)
            sh_eff = SH_W'(TOP_SH);
        else
            sh_eff = shift;
    end

    for (genvar g = 0; g <= TOP_SH; g++) begin : g_cand
        assign cand[g] = rounded[g+WIN_W-1:g];
    end

    assign win = cand[sh_eff];
endmodule

// File: rtl/sop_post_clamp.sv
`timescale 1ns/1ps
module sop_post_clamp #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] upper,
    input  logic [W-1:0] lower,
    input  logic         lim_en_n,
    output logic [W-1:0] res
);
    always_comb begin
        res = val;
        if (!lim_en_n) begin
            if ($signed(val) > $signed(upper))
                res = upper;
            else if ($signed(val) < $signed(lower))
                res = lower;
        end
    end
endmodule

// File: rtl/sop_post_stage.sv
`timescale 1ns/1ps
module sop_post_stage
    import sop_post_pkg::*;
#(
    parameter int S_W  = SUM_W,
    parameter int O_W  = OUT_W,
    parameter int NR   = NREG,
    parameter int SL_W = SEL_W,
    parameter int SH_W = SHIFT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [S_W-1:0]  sum_in,
    input  logic            acc_en,
    input  logic [SL_W-1:0] rnd_sel,
    input  logic [SH_W-1:0] shift_amt,
    input  logic [SL_W-1:0] lim_sel,
    input  logic            lim_en_n,
    input  logic            out_en_n,
    input  logic            rnd_wr_en,
    input  logic [SL_W-1:0] rnd_wr_idx,
    input  logic [S_W-1:0]  rnd_wr_data,
    input  logic            lim_wr_en,
    input  logic [SL_W-1:0] lim_wr_idx,
    input  logic [O_W-1:0]  lim_wr_upper,
    input  logic [O_W-1:0]  lim_wr_lower,
    output logic [O_W-1:0]  dout
);
    localparam int LIM_W = 2 * O_W;

    stage_ctrl_t      ctrl_q;
    logic [S_W-1:0]   acc_q;
    logic [S_W-1:0]   rnd_val;
    logic [LIM_W-1:0] lim_word;
    logic [O_W-1:0]   lim_up;
    logic [O_W-1:0]   lim_lo;
    logic [O_W-1:0]   win;
    logic [O_W-1:0]   clamped;
    logic             lim_active;

    // stage one: accumulator plus aligned control capture
    sop_post_accum #(.W(S_W)) accum_i (
        .clk    (clk),
        .rst    (rst),
        .acc_en (acc_en),
        .sum_in (sum_in),
        .acc_q  (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else
            ctrl_q <= '{rnd_sel:  rnd_sel,
                        shift:    sat_shift(shift_amt),
                        lim_sel:  lim_sel,
                        lim_en_n: lim_en_n,
                        out_en_n: out_en_n};
    end

    // register banks
    sop_post_regfile #(.W(S_W), .N(NR)) rnd_bank_i (
        .clk   (clk),
        .rst   (rst),
        .we    (rnd_wr_en),
        .widx  (rnd_wr_idx),
        .wdata (rnd_wr_data),
        .ridx  (ctrl_q.rnd_sel),
        .rdata (rnd_val)
    );

    sop_post_regfile #(.W(LIM_W), .N(NR)) lim_bank_i (
        .clk   (clk),
        .rst   (rst),
        .we    (lim_wr_en),
        .widx  (lim_wr_idx),
        .wdata ({lim_wr_upper, lim_wr_lower}),
        .ridx  (ctrl_q.lim_sel),
        .rdata (lim_word)
    );

    assign lim_up     = lim_word[LIM_W-1:O_W];
    assign lim_lo     = lim_word[O_W-1:0];
    assign lim_active = ~ctrl_q.lim_en_n;

    // stage two: round, window, clamp, output register
    sop_post_window #(.IN_W(S_W), .WIN_W(O_W), .SH_W(SH_W)) window_i (
        .acc   (acc_q),
        .rnd   (rnd_val),
        .shift (ctrl_q.shift),
        .win   (win)
    );

    sop_post_clamp #(.W(O_W)) clamp_i (
        .val      (win),
        .upper    (lim_up),
        .lower    (lim_lo),
        .lim_en_n (ctrl_q.lim_en_n),
        .res      (clamped)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (!ctrl_q.out_en_n)
            dout <= clamped;
    end
endmodule

// File: rtl/sop_post_chk.sv
`timescale 1ns/1ps
module sop_post_chk #(
    parameter int S_W = 32,
    parameter int O_W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           acc_en,
    input logic [S_W-1:0] sum_in,
    input logic           out_en_n,
    input logic [O_W-1:0] dout,
    input logic [S_W-1:0] acc_q,
    input logic           lim_active,
    input logic [O_W-1:0] lim_up,
    input logic [O_W-1:0] lim_lo,
    input logic [O_W-1:0] clamped
);
    // non-reset edges seen, saturating at 2
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            live_cnt <= '0;
        else if (live_cnt != 2'd2)
            live_cnt <= live_cnt + 2'd1;
    end

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == '0 && acc_q == '0));

    assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 2'd1 && !$past(acc_en)) |-> acc_q == $past(sum_in));

    assert_accumulate_R2: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 2'd1 && $past(acc_en)) |-> acc_q == S_W'($past(acc_q) + $past(sum_in)));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd2 && $past(out_en_n, 2)) |-> $stable(dout));

    assert_clamp_range_R5: assert property (@(posedge clk) disable iff (rst)
        (lim_active && $signed(lim_lo) <= $signed(lim_up)) |->
            ($signed(clamped) <= $signed(lim_up) && $signed(clamped) >= $signed(lim_lo)));
endmodule

bind sop_post_stage sop_post_chk #(.S_W(S_W), .O_W(O_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .sum_in     (sum_in),
    .out_en_n   (out_en_n),
    .dout       (dout),
    .acc_q      (acc_q),
    .lim_active (lim_active),
    .lim_up     (lim_up),
    .lim_lo     (lim_lo),
    .clamped    (clamped)
);

// File: tb/sop_post_stage_tb.sv
`timescale 1ns/1ps
module sop_post_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sum_in = '0;
    logic        acc_en = 1'b0;
    logic [3:0]  rnd_sel = '0;
    logic [4:0]  shift_amt = '0;
    logic [3:0]  lim_sel = '0;
    logic        lim_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        rnd_wr_en = 1'b0;
    logic [3:0]  rnd_wr_idx = '0;
    logic [31:0] rnd_wr_data = '0;
    logic        lim_wr_en = 1'b0;
    logic [3:0]  lim_wr_idx = '0;
    logic [15:0] lim_wr_upper = '0;
    logic [15:0] lim_wr_lower = '0;
    logic [15:0] dout;

    always #2 clk = ~clk;

    sop_post_stage dut_i (
        .clk(clk), .rst(rst), .sum_in(sum_in), .acc_en(acc_en),
        .rnd_sel(rnd_sel), .shift_amt(shift_amt), .lim_sel(lim_sel),
        .lim_en_n(lim_en_n), .out_en_n(out_en_n),
        .rnd_wr_en(rnd_wr_en), .rnd_wr_idx(rnd_wr_idx), .rnd_wr_data(rnd_wr_data),
        .lim_wr_en(lim_wr_en), .lim_wr_idx(lim_wr_idx),
        .lim_wr_upper(lim_wr_upper), .lim_wr_lower(lim_wr_lower),
        .dout(dout)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag  = "R12";
    bit    compare_on = 1'b0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // arithmetic reference model
    logic [31:0] m_acc;
    logic [31:0] m_rnd [16];
    logic [15:0] m_up  [16];
    logic [15:0] m_lo  [16];
    logic [3:0]  m_rs, m_ls;
    logic [4:0]  m_sh;
    logic        m_len, m_oen;
    logic [15:0] m_dout;

    always @(posedge clk) begin
        logic [31:0] rounded;
        logic [15:0] w;
        int          s;
        if (rst) begin
            m_acc = '0; m_dout = '0; m_rs = '0; m_ls = '0; m_sh = '0;
            m_len = 1'b1; m_oen = 1'b1;
            for (int i = 0; i < 16; i++) begin
                m_rnd[i] = '0; m_up[i] = '0; m_lo[i] = '0;
            end
        end else begin
            rounded = m_acc + m_rnd[m_rs];
            s = (int'(m_sh) > 16) ? 16 : int'(m_sh);
            w = 16'(rounded >> s);
            if (!m_len) begin
                if ($signed(w) > $signed(m_up[m_ls]))      w = m_up[m_ls];
                else if ($signed(w) < $signed(m_lo[m_ls])) w = m_lo[m_ls];
            end
            if (!m_oen) m_dout = w;
            m_acc = acc_en ? (m_acc + sum_in) : sum_in;
            m_rs = rnd_sel; m_sh = shift_amt; m_ls = lim_sel;
            m_len = lim_en_n; m_oen = out_en_n;
            if (rnd_wr_en) m_rnd[rnd_wr_idx] = rnd_wr_data;
            if (lim_wr_en) begin
                m_up[lim_wr_idx] = lim_wr_upper;
                m_lo[lim_wr_idx] = lim_wr_lower;
            end
        end
    end

    // every-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (compare_on && !rst)
            chk(dout === m_dout, cur_tag, {16'h0, dout}, {16'h0, m_dout});
    end

    task automatic step(input logic [31:0] s, input logic a, input logic [3:0] rs,
                        input logic [4:0] sh, input logic [3:0] ls,
                        input logic len, input logic oen);
        sum_in = s; acc_en = a; rnd_sel = rs; shift_amt = sh;
        lim_sel = ls; lim_en_n = len; out_en_n = oen;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dout == 16'h0, "R12", {16'h0, dout}, 32'h0);
        compare_on = 1'b1;

        // R11: load both banks
        cur_tag = "R11";
        for (int i = 0; i < 16; i++) begin
            rnd_wr_en = 1'b1; rnd_wr_idx = 4'(i);
            rnd_wr_data = (i == 0) ? 32'h0 : ((32'h1 << i) + 32'(i * 7));
            lim_wr_en = 1'b1; lim_wr_idx = 4'(i);
            if (i == 15) begin
                lim_wr_upper = 16'hFFFB; lim_wr_lower = 16'h0005; // crossed
            end else begin
                lim_wr_upper = 16'(100 * (i + 1));
                lim_wr_lower = 16'(-100 * (i + 1));
            end
            @(negedge clk);
        end
        rnd_wr_en = 1'b0; lim_wr_en = 1'b0;
        for (int i = 0; i < 16; i++)
            step(32'h0000_1000 + 32'(i), 1'b0, 4'(i), 5'd0, 4'd0, 1'b1, 1'b0);

        // R4: every shift value
        cur_tag = "R4";
        for (int s = 0; s < 32; s++)
            step(32'hA5C3_96E1 ^ (32'(s) * 32'h0101_0101), 1'b0, 4'd0, 5'(s), 4'd0, 1'b1, 1'b0);

        // R3: every rounding entry
        cur_tag = "R3";
        for (int r = 0; r < 16; r++)
            step(32'(1000 * r) - 32'd7000, 1'b0, 4'(r), 5'(r % 5), 4'd0, 1'b1, 1'b0);

        // R1 / R2: accumulate and restart patterns
        cur_tag = "R2";
        for (int k = 0; k < 24; k++)
            step(32'(k * 37) - 32'd300, (k % 5) != 0, 4'd1, 5'd0, 4'd0, 1'b1, 1'b0);
        cur_tag = "R1";
        for (int k = 0; k < 8; k++)
            step(32'h0001_0000 * 32'(k + 1), 1'b0, 4'd0, 5'd16, 4'd0, 1'b1, 1'b0);

        // R8: wrap at 2^32
        cur_tag = "R8";
        step(32'h7FFF_FFF0, 1'b0, 4'd0, 5'd16, 4'd0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++)
            step(32'h4000_0000, 1'b1, 4'd0, 5'd16, 4'd0, 1'b1, 1'b0);
        step(32'hFFFF_FFFF, 1'b0, 4'd15, 5'd0, 4'd0, 1'b1, 1'b0);
        step(32'hFFFF_FFFF, 1'b1, 4'd15, 5'd16, 4'd0, 1'b1, 1'b0);

        // R5 / R6: clamp at both bounds, and inside
        for (int ls = 0; ls < 15; ls++) begin
            cur_tag = "R5";
            step(32'(100 * (ls + 1) + 50), 1'b0, 4'd0, 5'd0, 4'(ls), 1'b0, 1'b0);
            cur_tag = "R6";
            step(32'(-100 * (ls + 1) - 50), 1'b0, 4'd0, 5'd0, 4'(ls), 1'b0, 1'b0);
            cur_tag = "R5";
            step(32'(ls * 3), 1'b0, 4'd0, 5'd0, 4'(ls), 1'b0, 1'b0);
        end
        cur_tag = "R6";
        for (int v = -8; v <= 8; v += 4)
            step(32'(v), 1'b0, 4'd0, 5'd0, 4'd15, 1'b0, 1'b0);

        // R7: bypass with the same out-of-range values
        cur_tag = "R7";
        for (int ls = 0; ls < 15; ls += 3)
            step(32'(100 * (ls + 1) + 50), 1'b0, 4'd0, 5'd0, 4'(ls), 1'b1, 1'b0);

        // R9: hold under high enable
        cur_tag = "R9";
        step(32'h0000_1234, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++)
            step(32'h0000_4000 + 32'(k), 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b1);
        step(32'h0000_0042, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);

        // R10: isolated impulse, exact two-edge latency
        cur_tag = "R10";
        step(32'h0000_0000, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step(32'h0000_0000, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        step(32'h0000_5A5A, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        chk(dout == 16'h0000, "R10", {16'h0, dout}, 32'h0);
        step(32'h0000_0000, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        chk(dout == 16'h5A5A, "R10", {16'h0, dout}, 32'h5A5A);
        step(32'h0000_0000, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        chk(dout == 16'h0000, "R10", {16'h0, dout}, 32'h0);

        repeat (3) step(32'h0, 1'b0, 4'd0, 5'd0, 4'd0, 1'b1, 1'b0);
        compare_on = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule